// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 32-bit operands and either writes the 64-bit product straight into a 64-bit accumulator or adds the product to it. The accumulator is seen as two 32-bit words, a high word and a low word. There are four operations:

- a signed 32x32 multiply;
- an unsigned 32x32 multiply;
- a signed 32x32 multiply-accumulate;
- a signed 16x16 multiply-accumulate on the low halves of the operands.

When the saturation-mode input is set, the two accumulate forms limit their result, each in its own way. The long form forces the upper bits of the high word. The halfword form clamps the sum to the signed 32-bit range and writes a marker value into the high word.

The unit has two pipeline stages. The first registers the product. The second combines that product with the accumulator and writes the result. A start strobe launches one operation per cycle, and a done pulse marks the cycle in which its result can be read. A clear command empties the accumulator.

Top module: `mac_sat_unit`

## Requirements
- R1: With op_i = 0 (signed multiply), the accumulator becomes the two's-complement 64-bit product of both operands: high word = product bits 63:32, low word = bits 31:0.
- R2: With op_i = 1 (unsigned multiply), the accumulator becomes the unsigned 64-bit product of both operands, split the same way.
- R3: With op_i = 2 (long accumulate) and sat_i low, the signed 64-bit product is added to {high,low}, wrapping modulo 2^64.
- R4: With op_i = 2 and sat_i high, if the 64-bit sum is negative, the high word becomes the sum's high word OR 0xFFFF0000.
- R5: With op_i = 2 and sat_i high, if the sum is not negative, the high word becomes the sum's high word AND 0x00007FFF. The low word is the sum's low word in both R4 and R5.
- R6: With op_i = 3 (halfword accumulate), the signed product of operand bits 15:0 is added to {high,low}. Operand bits 31:16 have no effect. With sat_i low the sum wraps modulo 2^64.
- R7: With op_i = 3 and sat_i high, a sum below -2^31 sets the high word to 1 and the low word to 0x80000000.
- R8: With op_i = 3 and sat_i high, a sum above 2^31-1 sets the high word to 1 and the low word to 0x7FFFFFFF. A sum within the range is written unchanged.
- R9: A cycle with clr_i high zeroes both accumulator words at the next clock edge.
- R10: An operation whose start_i is sampled at edge k shows its result, with done_o high for exactly one cycle, after edge k+1. done_o is never high without such a start.
- R11: The accumulator holds its value in every cycle without a completing operation or a clear, whatever op_i, sat_i and the operands do.
- R12: Starts in consecutive cycles are each applied in order, and each accumulate uses the result of the operation before it.
- R13: A clear in the same cycle as a completing operation wins: the accumulator becomes zero and done_o still pulses.
- R14: After reset both accumulator words are zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches one operation |
| op_i | input | 2 | Operation select: 0 signed mul, 1 unsigned mul, 2 long accumulate, 3 halfword accumulate |
| sat_i | input | 1 | Saturation mode for accumulate forms |
| clr_i | input | 1 | Zero the accumulator |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | One-cycle pulse when a result is written |

## Verification
The assertions assume that op_i and sat_i hold the values given with a start for as long as the checker looks back to them, two cycles, because the checker recovers the operation that is completing from the inputs. The stimulus therefore changes op_i and sat_i only together with a new start, or while no operation is in flight. The assertions also assume that clr_i is low across the release of reset. The directed tasks keep clr_i low except where a clear is under test.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_MULS = 2'd0,
        OP_MULU = 2'd1,
        OP_MACL = 2'd2,
        OP_MACW = 2'd3
    } mac_op_e;
endpackage

// File: rtl/mac_prod_gen.sv
// Stage-one product former: selects extension per operation, one multiplier.
module mac_prod_gen
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  mac_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod
);
    localparam int AW = 2 * DW;
    localparam int HW = DW / 2;

    logic [AW-1:0] ext_a, ext_b;

    always_comb begin
        unique case (op)
            OP_MULU: begin
                ext_a = {{DW{1'b0}}, a};
                ext_b = {{DW{1'b0}}, b};
            end
            OP_MACW: begin
                ext_a = {{(AW-HW){a[HW-1]}}, a[HW-1:0]};
                ext_b = {{(AW-HW){b[HW-1]}}, b[HW-1:0]};
            end
            default: begin
                ext_a = {{DW{a[DW-1]}}, a};
                ext_b = {{DW{b[DW-1]}}, b};
            end
        endcase
        prod = ext_a * ext_b;
    end
endmodule

// File: rtl/mac_wb_calc.sv
// Stage-two writeback value: overwrite, accumulate, and the two saturation rules.
module mac_wb_calc
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  mac_op_e         op,
    input  logic            sat,
    input  logic [2*DW-1:0] prod,
    input  logic [DW-1:0]   acc_hi,
    input  logic [DW-1:0]   acc_lo,
    output logic [DW-1:0]   nxt_hi,
    output logic [DW-1:0]   nxt_lo
);
    localparam int AW = 2 * DW;
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] HI_SET_MASK  = {{HW{1'b1}}, {HW{1'b0}}};
    localparam logic [DW-1:0] HI_KEEP_MASK = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [DW-1:0] CLAMP_MARK   = DW'(1);
    localparam logic [DW-1:0] CLAMP_NEG    = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] CLAMP_POS    = {1'b0, {(DW-1){1'b1}}};

    logic [AW-1:0] sum;
    logic          below_min, above_max;

    always_comb begin
        sum       = {acc_hi, acc_lo} + prod;
        // Fits in signed DW bits only if bits AW-1..DW-1 are all equal.
        below_min = sum[AW-1] && !(&sum[AW-1:DW-1]);
        above_max = !sum[AW-1] && (|sum[AW-1:DW-1]);
        nxt_hi    = sum[AW-1:DW];
        nxt_lo    = sum[DW-1:0];
        unique case (op)
            OP_MULS, OP_MULU: begin
                nxt_hi = prod[AW-1:DW];
                nxt_lo = prod[DW-1:0];
            end
            OP_MACL: begin
                if (sat) begin
                    nxt_hi = sum[AW-1] ? (sum[AW-1:DW] | HI_SET_MASK)
                                       : (sum[AW-1:DW] & HI_KEEP_MASK);
                end
            end
            OP_MACW: begin
                if (sat && below_min) begin
                    nxt_hi = CLAMP_MARK;
                    nxt_lo = CLAMP_NEG;
                end else if (sat && above_max) begin
                    nxt_hi = CLAMP_MARK;
                    nxt_lo = CLAMP_POS;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic          sat_i,
    input  logic          clr_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    output logic [DW-1:0] acc_hi_o,
    output logic [DW-1:0] acc_lo_o,
    output logic          done_o
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        logic          vld;
        mac_op_e       op;
        logic          sat;
        logic [AW-1:0] prod;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          done;
    } state_t;

    state_t        st_d, st_q;
    mac_op_e       op_in;
    logic [AW-1:0] prod_w;
    logic [DW-1:0] wb_hi, wb_lo;

    assign op_in = mac_op_e'(op_i);

    mac_prod_gen #(.DW(DW)) u_prod (
        .op   (op_in),
        .a    (opa_i),
        .b    (opb_i),
        .prod (prod_w)
    );

    mac_wb_calc #(.DW(DW)) u_wb (
        .op     (st_q.op),
        .sat    (st_q.sat),
        .prod   (st_q.prod),
        .acc_hi (st_q.hi),
        .acc_lo (st_q.lo),
        .nxt_hi (wb_hi),
        .nxt_lo (wb_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = start_i;
        st_d.done = st_q.vld;
        if (start_i) begin
            st_d.op   = op_in;
            st_d.sat  = sat_i;
            st_d.prod = prod_w;
        end
        if (st_q.vld) begin
            st_d.hi = wb_hi;
            st_d.lo = wb_lo;
        end
        if (clr_i) begin
            st_d.hi = '0;
            st_d.lo = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi_o = st_q.hi;
    assign acc_lo_o = st_q.lo;
    assign done_o   = st_q.done;
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    op_i,
    input logic          sat_i,
    input logic          clr_i,
    input logic [DW-1:0] acc_hi_o,
    input logic [DW-1:0] acc_lo_o,
    input logic          done_o
);
    localparam int AW = 2 * DW;
    localparam int HW = DW / 2;

    logic signed [AW-1:0] acc_s;
    assign acc_s = {acc_hi_o, acc_lo_o};

    // R10
    a_r10_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ##2 done_o);
    a_r10_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 2));

    // R9 and R13
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (acc_hi_o == '0 && acc_lo_o == '0));

    // R11
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(clr_i)) |-> ($stable(acc_hi_o) && $stable(acc_lo_o)));

    // R4 and R5: the high word's upper part is forced one way or the other
    a_r4_macl_sat_high_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(clr_i) && $past(op_i, 2) == OP_MACL && $past(sat_i, 2))
        |-> (acc_hi_o[DW-1:HW] == '1 || acc_hi_o[DW-1:HW-1] == '0));

    // R7 and R8: result in signed DW range or an exact clamp pattern
    a_r8_macw_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(clr_i) && $past(op_i, 2) == OP_MACW && $past(sat_i, 2))
        |-> ((acc_s >= -(AW'(1) <<< (DW-1)) && acc_s <= ((AW'(1) <<< (DW-1)) - 1))
             || (acc_hi_o == DW'(1) && (acc_lo_o == {1'b1, {(DW-1){1'b0}}}
                                        || acc_lo_o == {1'b0, {(DW-1){1'b1}}}))));
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .sat_i    (sat_i),
    .clr_i    (clr_i),
    .acc_hi_o (acc_hi_o),
    .acc_lo_o (acc_lo_o),
    .done_o   (done_o)
);

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        sat_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] acc_hi_o, acc_lo_o;
    logic        done_o;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          finished = 0;
    logic [63:0] ref_acc = '0;

    always #2 clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sat_i(sat_i),
        .clr_i(clr_i), .opa_i(opa_i), .opb_i(opb_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
    );

    function automatic logic [63:0] model(input logic [1:0] op, input logic sat,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
        logic signed [63:0] p, s;
        logic [31:0] hi;
        case (op)
            2'd0: return longint'($signed(a)) * longint'($signed(b));
            2'd1: return {32'd0, a} * {32'd0, b};
            2'd2: begin
                p = longint'($signed(a)) * longint'($signed(b));
                s = acc + p;
                if (!sat) return s;
                hi = s[63] ? (s[63:32] | 32'hFFFF0000) : (s[63:32] & 32'h00007FFF);
                return {hi, s[31:0]};
            end
            default: begin
                p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
                s = acc + p;
                if (sat && s < -64'sd2147483648) return {32'd1, 32'h80000000};
                if (sat && s > 64'sd2147483647) return {32'd1, 32'h7FFFFFFF};
                return s;
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a negedge; result and done are checked two negedges later.
    task automatic run_op(input string tag, input logic [1:0] op, input logic sat,
                          input logic [31:0] a, input logic [31:0] b);
        start_i = 1'b1; op_i = op; sat_i = sat; opa_i = a; opb_i = b;
        ref_acc = model(op, sat, a, b, ref_acc);
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R10 done low mid-flight"}, {63'd0, done_o}, 64'd0);
        @(negedge clk);
        chk({tag, " R10 done pulse"}, {63'd0, done_o}, 64'd1);
        chk(tag, {acc_hi_o, acc_lo_o}, ref_acc);
        @(negedge clk);
        chk({tag, " R10 done single cycle"}, {63'd0, done_o}, 64'd0);
    endtask

    task automatic do_clear(input string tag);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        ref_acc = '0;
        chk(tag, {acc_hi_o, acc_lo_o}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R14 reset acc", {acc_hi_o, acc_lo_o}, 64'd0);
        chk("R14 reset done", {63'd0, done_o}, 64'd0);
    endtask

    task automatic t_signed_mul();
        run_op("R1 signed neg*pos", 2'd0, 1'b0, 32'hFFFFFFFD, 32'h00000007);
        run_op("R1 signed min*min", 2'd0, 1'b0, 32'h80000000, 32'h80000000);
        run_op("R1 signed large", 2'd0, 1'b1, 32'h12345678, 32'h9ABCDEF0);
    endtask

    task automatic t_unsigned_mul();
        run_op("R2 unsigned max*max", 2'd1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run_op("R2 unsigned mixed", 2'd1, 1'b0, 32'h80000001, 32'h00000003);
    endtask

    task automatic t_macl_wrap();
        run_op("R3 preset all ones", 2'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001);
        run_op("R3 macl wraps to zero", 2'd2, 1'b0, 32'h00000001, 32'h00000001);
        run_op("R3 macl negative add", 2'd2, 1'b0, 32'hFFFFFFFE, 32'h00001000);
    endtask

    task automatic t_macl_sat_neg();
        run_op("R4 preset neg hi", 2'd1, 1'b0, 32'hC0000000, 32'hC0000000);
        run_op("R4 macl sat neg", 2'd2, 1'b1, 32'h00000001, 32'h00000001);
    endtask

    task automatic t_macl_sat_pos();
        run_op("R5 preset pos hi", 2'd1, 1'b0, 32'h40000000, 32'h12345678);
        run_op("R5 macl sat pos", 2'd2, 1'b1, 32'h00000001, 32'h00000001);
    endtask

    task automatic t_macw_wrap();
        run_op("R6 preset all ones", 2'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001);
        run_op("R6 macw upper halves ignored", 2'd3, 1'b0, 32'hABCD0002, 32'h12340003);
        run_op("R6 macw negative half", 2'd3, 1'b0, 32'h0000FFFF, 32'h00000005);
    endtask

    task automatic t_macw_clamp_low();
        do_clear("R9 clear before R7");
        run_op("R7 macw step1", 2'd3, 1'b1, 32'h00008000, 32'h00007FFF);
        run_op("R7 macw step2", 2'd3, 1'b1, 32'h00008000, 32'h00007FFF);
        run_op("R7 macw clamp low", 2'd3, 1'b1, 32'h00008000, 32'h00007FFF);
    endtask

    task automatic t_macw_clamp_high();
        do_clear("R9 clear before R8");
        run_op("R8 macw in range", 2'd3, 1'b1, 32'h00007FFF, 32'h00007FFF);
        run_op("R8 macw step2", 2'd3, 1'b1, 32'h00007FFF, 32'h00007FFF);
        run_op("R8 macw clamp high", 2'd3, 1'b1, 32'h00007FFF, 32'h00007FFF);
        run_op("R8 macw clamp again", 2'd3, 1'b1, 32'h00000001, 32'h00000001);
    endtask

    task automatic t_clear();
        run_op("R9 preset", 2'd1, 1'b0, 32'hDEADBEEF, 32'h00010001);
        do_clear("R9 clear zeroes acc");
    endtask

    task automatic t_hold();
        run_op("R11 preset", 2'd1, 1'b0, 32'h13579BDF, 32'h2468ACE0);
        for (int i = 0; i < 6; i++) begin
            op_i = 2'(i); sat_i = i[0]; opa_i = 32'h1111 * (i + 3); opb_i = ~opa_i;
            @(negedge clk);
        end
        chk("R11 acc held while idle", {acc_hi_o, acc_lo_o}, ref_acc);
    endtask

    task automatic t_back2back();
        logic [63:0] e1, e2, e3;
        do_clear("R9 clear before R12");
        e1 = model(2'd2, 1'b0, 32'h00000100, 32'h00000200, 64'd0);
        e2 = model(2'd2, 1'b0, 32'hFFFFFFFF, 32'h00000300, e1);
        e3 = model(2'd3, 1'b0, 32'h00000010, 32'h00000010, e2);
        start_i = 1'b1; op_i = 2'd2; sat_i = 1'b0; opa_i = 32'h100; opb_i = 32'h200;
        @(negedge clk);
        opa_i = 32'hFFFFFFFF; opb_i = 32'h300;
        @(negedge clk);
        chk("R12 first result", {acc_hi_o, acc_lo_o}, e1);
        op_i = 2'd3; opa_i = 32'h10; opb_i = 32'h10;
        @(negedge clk);
        start_i = 1'b0;
        chk("R12 second result", {acc_hi_o, acc_lo_o}, e2);
        chk("R12 done stays high", {63'd0, done_o}, 64'd1);
        @(negedge clk);
        chk("R12 third result", {acc_hi_o, acc_lo_o}, e3);
        @(negedge clk);
        chk("R12 done drops", {63'd0, done_o}, 64'd0);
        ref_acc = e3;
    endtask

    task automatic t_clear_priority();
        start_i = 1'b1; op_i = 2'd2; sat_i = 1'b0; opa_i = 32'h7; opb_i = 32'h9;
        @(negedge clk);
        start_i = 1'b0;
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        ref_acc = '0;
        chk("R13 clear beats writeback", {acc_hi_o, acc_lo_o}, 64'd0);
        chk("R13 done still pulses", {63'd0, done_o}, 64'd1);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_mul();
        t_unsigned_mul();
        t_macl_wrap();
        t_macl_sat_neg();
        t_macl_sat_pos();
        t_macw_wrap();
        t_macw_clamp_low();
        t_macw_clamp_high();
        t_clear();
        t_hold();
        t_back2back();
        t_clear_priority();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule